// File: doc/BRIEF.md
# Serial Memory Write Guard

This block keeps the status register of a small serial nonvolatile memory and rules on every write that the command engine wants to make. The engine hands it one-cycle event strobes for the enable, disable and status-load commands, the byte offered for the status register, a strobe marking the end of a write transaction, the level of the active-low hardware protect pin and the byte address being written. The block answers with the status byte to shift out on a status read, a grant for a memory byte write at the current address and a grant for a status load.

The four stored bits are a write-enable flag, two block-protect bits that select a region at the top of the array, and a lock bit that makes the protect pin guard the status register. The three stored protection bits stand in for nonvolatile cells and are ordinary registers with parameter reset values. The enable flag always resets clear. The engine is expected to drop any byte whose grant is low and still advance its address counter. It pulses the end-of-write strobe once, when chip select rises after a memory write, so a sequential burst is not cut short after its first byte.

Top module: `spwProtect`

## Requirements
- R1: The status byte holds the lock bit in bit 7, block-protect high in bit 3, block-protect low in bit 2 and the enable flag in bit 1. Bits 6, 5, 4 and 0 always read 0. After reset the enable flag is 0 and the other stored bits take their parameter reset values, which are 0 by default.
- R2: The enable strobe sets the enable flag at the next clock edge. The disable strobe clears it. Bit 1 of a status-load byte never changes it.
- R3: The end-of-write strobe clears the enable flag at the next edge. An accepted status load clears it too.
- R4: When a clearing cause and the enable strobe come in the same cycle, the flag ends up 0.
- R5: With the enable flag set, the memory grant depends on the protect bits and the 13-bit address. Code 00 grants every address. Code 01 refuses 0x1800 to 0x1FFF. Code 10 refuses 0x1000 to 0x1FFF. Code 11 refuses all addresses.
- R6: While the enable flag is 0, the memory grant and the status grant are both 0.
- R7: With the enable flag set and the lock bit 0, the status grant is 1 whatever the protect pin level.
- R8: With the enable flag set and the lock bit 1, the status grant equals the protect pin level: 0 when the pin is low and 1 when it is high.
- R9: A status load that comes while the status grant is 0 changes no stored bit, and it does not clear the enable flag.
- R10: Both grants are combinational. They follow a change of address or pin in the same cycle, with no clock edge in between.
- R11: An accepted status load copies bits 7, 3 and 2 of the offered byte into the lock and protect bits. The new values show in the status byte after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrenEvt | input | 1 | One-cycle strobe: enable writes |
| wrdiEvt | input | 1 | One-cycle strobe: disable writes |
| wrsrEvt | input | 1 | One-cycle strobe: load status register |
| wrsrData | input | 8 | Byte offered for the status load |
| writeDone | input | 1 | One-cycle strobe: a memory write transaction ended |
| wpN | input | 1 | Hardware protect pin level, active low |
| addr | input | 13 | Byte address of the pending memory write |
| statusByte | output | 8 | Status register as read out |
| memWriteOk | output | 1 | Grant for a memory byte write at addr |
| statusWriteOk | output | 1 | Grant for a status load |

## Verification
The two grants have zero latency. The bench drives its inputs at the falling edge and compares both grants a quarter period later, before the next rising edge, against the state held in its model. Every change to the status byte is due exactly one rising edge after the strobe that causes it. The bench therefore updates its model at that edge and samples the status byte a quarter period after it, so each comparison sees the effect of exactly one step of stimulus.

// File: rtl/spwPkg.sv
package spwPkg;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic setWel;   // enable flag set request
    logic clrWel;   // enable flag clear request (dominates setWel)
    logic loadSr;   // accepted status load
  } spwStrobes_t;

  // bit positions inside the status byte; read-back software decodes these
  localparam int unsigned SR_LOCK = 7;
  localparam int unsigned SR_BPH  = 3;
  localparam int unsigned SR_BPL  = 2;
  localparam int unsigned SR_WEL  = 1;
  localparam int unsigned SR_W    = 8;

endpackage

// File: rtl/spwCtrl.sv
module spwCtrl
  import spwPkg::*;
(
  input  logic        wrenEvt,
  input  logic        wrdiEvt,
  input  logic        wrsrEvt,
  input  logic        writeDone,
  input  logic        wpN,
  input  logic        welQ,
  input  logic        lockQ,
  output logic        statusWriteOk,
  output spwStrobes_t strobes
);

  logic pinAllows;

  // the pin matters only when the lock bit is set
  always_comb begin
    pinAllows     = !lockQ || wpN;
    statusWriteOk = welQ && pinAllows;
  end

  always_comb begin
    strobes        = '0;
    strobes.loadSr = wrsrEvt && statusWriteOk;
    strobes.setWel = wrenEvt;
    // disable, end of a write burst, or a status load that took effect
    strobes.clrWel = wrdiEvt || writeDone || strobes.loadSr;
  end

endmodule

// File: rtl/spwDatapath.sv
module spwDatapath
  import spwPkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter logic        RST_LOCK = 1'b0,
  parameter logic [1:0]  RST_BP   = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  spwStrobes_t       strobes,
  input  logic [SR_W-1:0]   srData,
  input  logic [ADDR_W-1:0] addr,
  output logic [SR_W-1:0]   statusByte,
  output logic              welQ,
  output logic              lockQ,
  output logic              memWriteOk
);

  localparam int unsigned TOP = ADDR_W - 1;

  logic [1:0] bpQ;
  logic       inTopHalf;
  logic       inTopQuarter;
  logic       regionLocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ <= 1'b0;
    end else if (strobes.clrWel) begin
      welQ <= 1'b0;
    end else if (strobes.setWel) begin
      welQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= RST_LOCK;
      bpQ   <= RST_BP;
    end else if (strobes.loadSr) begin
      lockQ <= srData[SR_LOCK];
      bpQ   <= {srData[SR_BPH], srData[SR_BPL]};
    end
  end

  // region decode on the top address bits
  generate
    if (ADDR_W >= 2) begin : gWide
      always_comb begin
        inTopHalf    = addr[TOP];
        inTopQuarter = addr[TOP] && addr[TOP-1];
      end
    end else begin : gNarrow
      always_comb begin
        inTopHalf    = addr[0];
        inTopQuarter = addr[0];
      end
    end
  endgenerate

  always_comb begin
    unique case (bpQ)
      2'b00:   regionLocked = 1'b0;
      2'b01:   regionLocked = inTopQuarter;
      2'b10:   regionLocked = inTopHalf;
      default: regionLocked = 1'b1;
    endcase
    memWriteOk = welQ && !regionLocked;
  end

  always_comb begin
    statusByte          = '0;
    statusByte[SR_LOCK] = lockQ;
    statusByte[SR_BPH]  = bpQ[1];
    statusByte[SR_BPL]  = bpQ[0];
    statusByte[SR_WEL]  = welQ;
  end

endmodule

// File: rtl/spwProtect.sv
module spwProtect
  import spwPkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter logic        RST_LOCK = 1'b0,
  parameter logic [1:0]  RST_BP   = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrenEvt,
  input  logic              wrdiEvt,
  input  logic              wrsrEvt,
  input  logic [7:0]        wrsrData,
  input  logic              writeDone,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        statusByte,
  output logic              memWriteOk,
  output logic              statusWriteOk
);

  spwStrobes_t strobes;
  logic        welQ;
  logic        lockQ;

  spwCtrl uCtrl (
    .wrenEvt      (wrenEvt),
    .wrdiEvt      (wrdiEvt),
    .wrsrEvt      (wrsrEvt),
    .writeDone    (writeDone),
    .wpN          (wpN),
    .welQ         (welQ),
    .lockQ        (lockQ),
    .statusWriteOk(statusWriteOk),
    .strobes      (strobes)
  );

  spwDatapath #(
    .ADDR_W  (ADDR_W),
    .RST_LOCK(RST_LOCK),
    .RST_BP  (RST_BP)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srData    (wrsrData),
    .addr      (addr),
    .statusByte(statusByte),
    .welQ      (welQ),
    .lockQ     (lockQ),
    .memWriteOk(memWriteOk)
  );

endmodule

// File: rtl/spwProtect_chk.sv
module spwProtect_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrenEvt,
  input logic       wrdiEvt,
  input logic       wrsrEvt,
  input logic       writeDone,
  input logic       wpN,
  input logic [7:0] statusByte,
  input logic       memWriteOk,
  input logic       statusWriteOk
);

  always @(negedge clk) begin
    if (rstN) begin
      assert_fixed_zero_R1: assert (statusByte[6:4] == 3'b000 && statusByte[0] == 1'b0)
        else $error("fixed status bits not zero");
    end
  end

  assert_wel_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[1]) |-> $past(wrenEvt));

  assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    writeDone |=> !statusByte[1]);

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrenEvt && wrdiEvt) |=> !statusByte[1]);

  assert_full_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] == 2'b11) |-> !memWriteOk);

  assert_no_wel_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[1] |-> (!memWriteOk && !statusWriteOk));

  assert_pin_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[1] && !statusByte[7]) |-> statusWriteOk);

  assert_pin_locks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && !wpN) |-> !statusWriteOk);

  assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrsrEvt && !statusWriteOk && !wrenEvt && !wrdiEvt && !writeDone)
      |=> $stable(statusByte));

endmodule

bind spwProtect spwProtect_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .wrenEvt      (wrenEvt),
  .wrdiEvt      (wrdiEvt),
  .wrsrEvt      (wrsrEvt),
  .writeDone    (writeDone),
  .wpN          (wpN),
  .statusByte   (statusByte),
  .memWriteOk   (memWriteOk),
  .statusWriteOk(statusWriteOk)
);

// File: tb/spwProtect_test.sv
module spwProtect_test;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrenEvt = 1'b0, wrdiEvt = 1'b0, wrsrEvt = 1'b0, writeDone = 1'b0;
  logic [7:0]  wrsrData = 8'h00;
  logic        wpN = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  statusByte;
  logic        memWriteOk, statusWriteOk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  logic       mWel = 1'b0;
  logic       mLock = 1'b0;
  logic [1:0] mBp = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spwProtect uut (
    .clk(clk), .rstN(rstN), .wrenEvt(wrenEvt), .wrdiEvt(wrdiEvt),
    .wrsrEvt(wrsrEvt), .wrsrData(wrsrData), .writeDone(writeDone),
    .wpN(wpN), .addr(addr), .statusByte(statusByte),
    .memWriteOk(memWriteOk), .statusWriteOk(statusWriteOk)
  );

  function automatic logic expMem(logic wel, logic [1:0] bp, logic [12:0] a);
    logic refused;
    case (bp)
      2'b00:   refused = 1'b0;
      2'b01:   refused = (a >= 13'h1800);
      2'b10:   refused = (a >= 13'h1000);
      default: refused = 1'b1;
    endcase
    return wel && !refused;
  endfunction

  function automatic logic expSr(logic wel, logic lock, logic pin);
    return wel && (!lock || pin);
  endfunction

  function automatic logic [7:0] expStatus();
    return {mLock, 3'b000, mBp, mWel, 1'b0};
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // one cycle of stimulus: grants checked before the edge, status after it
  task automatic step(input logic wr, input logic wd, input logic ws, input logic dn,
                      input logic [7:0] d, input logic pin, input logic [12:0] a);
    logic ok;
    @(negedge clk);
    wrenEvt = wr; wrdiEvt = wd; wrsrEvt = ws; writeDone = dn;
    wrsrData = d; wpN = pin; addr = a;
    #(CLK_PERIOD/4);
    check({7'd0, memWriteOk}, {7'd0, expMem(mWel, mBp, a)}, mWel ? "R5 R10" : "R6");
    ok = expSr(mWel, mLock, pin);
    check({7'd0, statusWriteOk}, {7'd0, ok}, !mWel ? "R6" : (mLock ? "R8" : "R7"));
    @(posedge clk);
    if (ws && ok) begin
      mLock = d[7];
      mBp   = d[3:2];
    end
    if (wd || dn || (ws && ok)) mWel = 1'b0;
    else if (wr) mWel = 1'b1;
    #(CLK_PERIOD/4);
    check(statusByte, expStatus(), "R1 R2 R3 R4 R9 R11");
  endtask

  task automatic idle(input logic pin, input logic [12:0] a);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, pin, a);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R1: reset value
    check(statusByte, 8'h00, "R1");
    check({7'd0, memWriteOk}, 8'h00, "R6");
    @(negedge clk);
    rstN = 1'b1;

    // R2: enable, then a status load with bit 1 clear and bit 0 set
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 13'h0000);
    check(statusByte, 8'h02, "R2");
    // R11: load lock=1 bp=01, garbage in fixed bits; R3: flag cleared
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'hF5, 1'b1, 13'h0000);
    check(statusByte, 8'h84, "R11 R3");
    // R6: no grant with flag clear
    idle(1'b1, 13'h0000);
    // R5 boundaries of code 01
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 13'h17FF);
    check({7'd0, memWriteOk}, 8'h01, "R5");
    idle(1'b1, 13'h1800);
    check({7'd0, memWriteOk}, 8'h00, "R5");
    // R8: pin low with lock set refuses; R9: rejected load keeps everything
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h0C, 1'b0, 13'h0FFF);
    check(statusByte, 8'h86, "R9");
    // R8 then R11: pin high allows load lock=0 bp=10
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h08, 1'b1, 13'h1000);
    check(statusByte, 8'h08, "R11");
    // R4: enable together with end-of-write
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 13'h0FFF);
    check(statusByte, 8'h08, "R4");
    // R5 code 10 boundaries, R10 address change same cycle
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 13'h0FFF);
    idle(1'b0, 13'h1000);
    idle(1'b0, 13'h0000);
    // R7: lock clear, pin low, load allowed: bp=11
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h0E, 1'b0, 13'h0000);
    check(statusByte, 8'h0C, "R7 R11");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 13'h0000);
    idle(1'b1, 13'h0000);
    check({7'd0, memWriteOk}, 8'h00, "R5");
    // R3: end-of-write clears; R2: disable clears
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 13'h0000);
    check(statusByte, 8'h0C, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 13'h0000);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 13'h0000);
    check(statusByte, 8'h0C, "R2");

    // random mix
    for (int i = 0; i < RAND_STEPS; i++) begin
      int unsigned sel = $urandom % 16;
      logic [12:0] a;
      int unsigned asel = $urandom % 4;
      case (asel)
        0: a = 13'h17FF + 13'($urandom % 2);
        1: a = 13'h0FFF + 13'($urandom % 2);
        default: a = 13'($urandom);
      endcase
      step(sel < 4, sel == 4 || sel == 11, sel >= 5 && sel <= 8,
           sel == 9 || sel == 10, 8'($urandom), 1'($urandom), a);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule